// File: doc/BRIEF.md
# Dual-Clock FIFO with Threshold Flags and Read Rewind

This block carries data words from a write clock domain to an unrelated read clock domain through an inferred dual-port array. Each side has a request and a clock enable of its own. A word is stored on a write-clock edge only when both are high and the FIFO is not full. A word is removed on a read-clock edge only when both read-side inputs are high and the FIFO is not empty. The read port shows the oldest stored word directly from the array, so the data is valid whenever the empty flag is low.

Four status flags come out. The two fill flags are registered on the write clock and the two drain flags on the read clock. Their thresholds are parameters. The pointers cross between domains in Gray code through two-stage synchronizers. Each side therefore sees its own pointer at once and the other side's pointer a few cycles late, which makes every flag err on the safe side. An asynchronous global reset clears both pointers and all flags. A second asynchronous reset moves only the read pointer back to the first location after the global reset, so a packet written since then can be read out again.

Top module: `flagged_async_fifo`

## Requirements
- R1: While the global reset is low, and on its release, empty and almost-empty read 1 and full and almost-full read 0. This holds even when the global reset is pulsed while words are stored.
- R2: Words leave the read port in the same order they were written. The read data port shows the oldest unread word whenever empty is 0.
- R3: Full is registered on the write clock. It reads 1 from the write edge that brings the write-side level (words written minus words the write side knows to be read) to FULL_THR or above, where 1 <= FULL_THR <= 2^ADDR_W-1.
- R4: Almost-full is registered on the write clock. It reads 1 whenever the write-side level is at least AFULL_THR, where 1 <= AFULL_THR <= FULL_THR-1.
- R5: Empty and almost-empty are registered on the read clock. Empty is 1 when the read-side level is 0. Almost-empty is 1 when that level is at most AEMPTY_THR, where 1 <= AEMPTY_THR <= FULL_THR-1.
- R6: A write request while full is ignored: no word is stored and the write pointer does not move. A read request while empty is ignored and the read pointer does not move.
- R7: A word is accepted only on a write-clock edge where both write enable and write clock enable are 1. A word is removed only on a read-clock edge where both read enable and read clock enable are 1.
- R8: A low pulse on the read-pointer reset returns the read pointer to the first location after the global reset and leaves the write pointer untouched, so the stored packet is read out again.
- R9: A write becomes visible to the read-side flags within three read-clock edges, and a read frees space on the write-side flags within three write-clock edges. Each pointer moves by at most one Gray-code bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Global asynchronous reset, active low |
| rd_ptr_rst_n | input | 1 | Asynchronous read-pointer rewind, active low |
| wr_clk | input | 1 | Write clock |
| wr_en | input | 1 | Write request |
| wr_ce | input | 1 | Write clock enable |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | Level at or above FULL_THR (write clock) |
| afull | output | 1 | Level at or above AFULL_THR (write clock) |
| rd_clk | input | 1 | Read clock |
| rd_en | input | 1 | Read request |
| rd_ce | input | 1 | Read clock enable |
| rd_data | output | DATA_W | Oldest unread word |
| empty | output | 1 | No word visible (read clock) |
| aempty | output | 1 | Level at or below AEMPTY_THR (read clock) |

## Verification
The effect of a port's own action on its own flags is due on the clock edge that commits the action. The bench therefore checks full and almost-full at the first falling write edge after a write, and empty and almost-empty at the first falling read edge after a read. An effect that crosses domains needs up to three edges of the destination clock: two synchronizer stages and the flag register. The bench waits five edges of both clocks before it checks a crossed result. It checks the full-flag release exactly four falling write edges after a read. The two clocks run with a fixed phase offset, so no check falls on an edge of either clock.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

    localparam int CONV_W = 32;

    function automatic logic [CONV_W-1:0] bin2gray(input logic [CONV_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [CONV_W-1:0] gray2bin(input logic [CONV_W-1:0] g);
        logic [CONV_W-1:0] b;
        b[CONV_W-1] = g[CONV_W-1];
        for (int i = CONV_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/afifo_ptr_sync.sv
module afifo_ptr_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] ptr_in,
    output logic [W-1:0] ptr_out
);
    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stage1 = ptr_in;
        st_d.stage2 = st_q.stage1;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ptr_out = st_q.stage2;
endmodule

// File: rtl/afifo_store.sv
module afifo_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/afifo_wr_ctl.sv
module afifo_wr_ctl #(
    parameter int ADDR_W    = 4,
    parameter int FULL_THR  = 15,
    parameter int AFULL_THR = 12
) (
    input  logic              wr_clk,
    input  logic              arst_n,
    input  logic              wr_en,
    input  logic              wr_ce,
    input  logic [ADDR_W:0]   rd_gray_sync,
    output logic              push,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wr_gray,
    output logic              full,
    output logic              afull
);
    localparam int PTR_W = ADDR_W + 1;
    localparam logic [PTR_W-1:0] FULL_LIM  = PTR_W'(FULL_THR);
    localparam logic [PTR_W-1:0] AFULL_LIM = PTR_W'(AFULL_THR);

    typedef struct packed {
        logic [PTR_W-1:0] bin;
        logic [PTR_W-1:0] gray;
        logic             full;
        logic             afull;
    } wr_state_t;

    wr_state_t        st_d, st_q;
    logic [PTR_W-1:0] rd_bin_seen;
    logic [PTR_W-1:0] level_d;

    always_comb begin
        st_d        = st_q;
        push        = wr_en && wr_ce && !st_q.full;
        st_d.bin    = st_q.bin + PTR_W'(push);
        st_d.gray   = PTR_W'(afifo_pkg::bin2gray(32'(st_d.bin)));
        rd_bin_seen = PTR_W'(afifo_pkg::gray2bin(32'(rd_gray_sync)));
        level_d     = st_d.bin - rd_bin_seen;
        st_d.full   = (level_d >= FULL_LIM);
        st_d.afull  = (level_d >= AFULL_LIM);
    end

    always_ff @(posedge wr_clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign waddr   = st_q.bin[ADDR_W-1:0];
    assign wr_gray = st_q.gray;
    assign full    = st_q.full;
    assign afull   = st_q.afull;
endmodule

// File: rtl/afifo_rd_ctl.sv
module afifo_rd_ctl #(
    parameter int ADDR_W     = 4,
    parameter int AEMPTY_THR = 3
) (
    input  logic              rd_clk,
    input  logic              arst_n,
    input  logic              rd_en,
    input  logic              rd_ce,
    input  logic [ADDR_W:0]   wr_gray_sync,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rd_gray,
    output logic              empty,
    output logic              aempty
);
    localparam int PTR_W = ADDR_W + 1;
    localparam logic [PTR_W-1:0] AEMPTY_LIM = PTR_W'(AEMPTY_THR);

    typedef struct packed {
        logic [PTR_W-1:0] bin;
        logic [PTR_W-1:0] gray;
        logic             empty;
        logic             aempty;
    } rd_state_t;

    localparam rd_state_t RD_RST = '{bin: '0, gray: '0, empty: 1'b1, aempty: 1'b1};

    rd_state_t        st_d, st_q;
    logic             pop;
    logic [PTR_W-1:0] wr_bin_seen;
    logic [PTR_W-1:0] level_d;

    always_comb begin
        st_d        = st_q;
        pop         = rd_en && rd_ce && !st_q.empty;
        st_d.bin    = st_q.bin + PTR_W'(pop);
        st_d.gray   = PTR_W'(afifo_pkg::bin2gray(32'(st_d.bin)));
        wr_bin_seen = PTR_W'(afifo_pkg::gray2bin(32'(wr_gray_sync)));
        level_d     = wr_bin_seen - st_d.bin;
        st_d.empty  = (level_d == '0);
        st_d.aempty = (level_d <= AEMPTY_LIM);
    end

    always_ff @(posedge rd_clk or negedge arst_n) begin
        if (!arst_n) st_q <= RD_RST;
        else         st_q <= st_d;
    end

    assign raddr   = st_q.bin[ADDR_W-1:0];
    assign rd_gray = st_q.gray;
    assign empty   = st_q.empty;
    assign aempty  = st_q.aempty;
endmodule

// File: rtl/flagged_async_fifo.sv
module flagged_async_fifo #(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 4,
    parameter int FULL_THR   = 15,
    parameter int AFULL_THR  = 12,
    parameter int AEMPTY_THR = 3
) (
    input  logic              rst_n,
    input  logic              rd_ptr_rst_n,
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic              wr_ce,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    output logic              afull,
    input  logic              rd_clk,
    input  logic              rd_en,
    input  logic              rd_ce,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              aempty
);
    localparam int PTR_W = ADDR_W + 1;

    logic              push_w;
    logic [ADDR_W-1:0] waddr_w;
    logic [ADDR_W-1:0] raddr_w;
    logic [PTR_W-1:0]  wr_gray_w;
    logic [PTR_W-1:0]  rd_gray_w;
    logic [PTR_W-1:0]  wr_gray_in_rd;
    logic [PTR_W-1:0]  rd_gray_in_wr;
    logic              rd_side_rst_n;

    assign rd_side_rst_n = rst_n && rd_ptr_rst_n;

    afifo_wr_ctl #(
        .ADDR_W   (ADDR_W),
        .FULL_THR (FULL_THR),
        .AFULL_THR(AFULL_THR)
    ) u_wr (
        .wr_clk      (wr_clk),
        .arst_n      (rst_n),
        .wr_en       (wr_en),
        .wr_ce       (wr_ce),
        .rd_gray_sync(rd_gray_in_wr),
        .push        (push_w),
        .waddr       (waddr_w),
        .wr_gray     (wr_gray_w),
        .full        (full),
        .afull       (afull)
    );

    afifo_rd_ctl #(
        .ADDR_W    (ADDR_W),
        .AEMPTY_THR(AEMPTY_THR)
    ) u_rd (
        .rd_clk      (rd_clk),
        .arst_n      (rd_side_rst_n),
        .rd_en       (rd_en),
        .rd_ce       (rd_ce),
        .wr_gray_sync(wr_gray_in_rd),
        .raddr       (raddr_w),
        .rd_gray     (rd_gray_w),
        .empty       (empty),
        .aempty      (aempty)
    );

    afifo_ptr_sync #(.W(PTR_W)) u_sync_w2r (
        .clk    (rd_clk),
        .arst_n (rst_n),
        .ptr_in (wr_gray_w),
        .ptr_out(wr_gray_in_rd)
    );

    afifo_ptr_sync #(.W(PTR_W)) u_sync_r2w (
        .clk    (wr_clk),
        .arst_n (rst_n),
        .ptr_in (rd_gray_w),
        .ptr_out(rd_gray_in_wr)
    );

    afifo_store #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_store (
        .wr_clk(wr_clk),
        .we    (push_w),
        .waddr (waddr_w),
        .wdata (wr_data),
        .raddr (raddr_w),
        .rdata (rd_data)
    );
endmodule

// File: rtl/flagged_async_fifo_chk.sv
module flagged_async_fifo_chk #(
    parameter int ADDR_W = 4
) (
    input logic          rst_n,
    input logic          rd_ptr_rst_n,
    input logic          wr_clk,
    input logic          wr_en,
    input logic          wr_ce,
    input logic          full,
    input logic          afull,
    input logic          rd_clk,
    input logic          rd_en,
    input logic          rd_ce,
    input logic          empty,
    input logic          aempty,
    input logic [ADDR_W:0] wr_gray,
    input logic [ADDR_W:0] rd_gray
);
    // Full level is never below the almost-full level.
    assert_full_has_afull_R4: assert property (@(posedge wr_clk) disable iff (!rst_n)
        full |-> afull);

    // A level of zero is always within the almost-empty band.
    assert_empty_has_aempty_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        empty |-> aempty);

    assert_no_overflow_R6: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (full && wr_en && wr_ce) |=> $stable(wr_gray));

    assert_no_underflow_R6: assert property (@(posedge rd_clk) disable iff (!rst_n || !rd_ptr_rst_n)
        (empty && rd_en && rd_ce) |=> $stable(rd_gray));

    assert_wr_hold_without_ce_R7: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !wr_ce |=> $stable(wr_gray));

    assert_rewind_to_start_R8: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $rose(rd_ptr_rst_n) |-> (rd_gray == '0));

    assert_wr_gray_step_R9: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $onehot0(wr_gray ^ $past(wr_gray)));
endmodule

bind flagged_async_fifo flagged_async_fifo_chk #(.ADDR_W(ADDR_W)) u_chk (
    .rst_n       (rst_n),
    .rd_ptr_rst_n(rd_ptr_rst_n),
    .wr_clk      (wr_clk),
    .wr_en       (wr_en),
    .wr_ce       (wr_ce),
    .full        (full),
    .afull       (afull),
    .rd_clk      (rd_clk),
    .rd_en       (rd_en),
    .rd_ce       (rd_ce),
    .empty       (empty),
    .aempty      (aempty),
    .wr_gray     (wr_gray_w),
    .rd_gray     (rd_gray_w)
);

// File: tb/flagged_async_fifo_tb.sv
`timescale 1ns/1ps
module flagged_async_fifo_tb;
    localparam int DW    = 8;
    localparam int FTHR  = 15;
    localparam int AFTHR = 12;
    localparam int AETHR = 3;

    logic          rst_n = 1'b0, rd_ptr_rst_n = 1'b1;
    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          wr_en = 1'b0, wr_ce = 1'b1, rd_en = 1'b0, rd_ce = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          full, afull, empty, aempty;

    int  n_tests = 0, n_fail = 0;
    bit  done = 1'b0;

    flagged_async_fifo #(
        .DATA_W(DW), .ADDR_W(4), .FULL_THR(FTHR), .AFULL_THR(AFTHR), .AEMPTY_THR(AETHR)
    ) u_dut (
        .rst_n(rst_n), .rd_ptr_rst_n(rd_ptr_rst_n),
        .wr_clk(wr_clk), .wr_en(wr_en), .wr_ce(wr_ce), .wr_data(wr_data),
        .full(full), .afull(afull),
        .rd_clk(rd_clk), .rd_en(rd_en), .rd_ce(rd_ce), .rd_data(rd_data),
        .empty(empty), .aempty(aempty)
    );

    always #5 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #5 rd_clk = ~rd_clk;
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge rd_clk);
        repeat (5) @(negedge wr_clk);
    endtask

    task automatic global_reset();
        @(negedge wr_clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_ce = 1'b1; rd_ce = 1'b1;
        repeat (3) @(negedge wr_clk);
        rst_n = 1'b1;
        settle();
    endtask

    task automatic push_word(input logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic pop_word(output logic [DW-1:0] d);
        @(negedge rd_clk);
        d = rd_data;
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
    endtask

    task automatic test_reset_state();
        rst_n = 1'b0;
        repeat (2) @(negedge wr_clk);
        chk("R1 empty in reset", 32'(empty), 1);
        chk("R1 full in reset", 32'(full), 0);
        rst_n = 1'b1;
        settle();
        chk("R1 empty after reset", 32'(empty), 1);
        chk("R1 aempty after reset", 32'(aempty), 1);
        chk("R1 full after reset", 32'(full), 0);
        chk("R1 afull after reset", 32'(afull), 0);
    endtask

    task automatic test_fill_drain();
        logic [DW-1:0] d;
        global_reset();
        for (int i = 1; i <= FTHR; i++) begin
            push_word(DW'(8'h40 + i));
            chk($sformatf("R4 afull after write %0d", i), 32'(afull), 32'(i >= AFTHR));
            chk($sformatf("R3 full after write %0d", i), 32'(full), 32'(i >= FTHR));
        end
        push_word(8'hEE);
        chk("R6 full held after write while full", 32'(full), 1);
        settle();
        chk("R9 empty cleared after crossing", 32'(empty), 0);
        pop_word(d);
        chk("R2 first word", 32'(d), 32'h41);
        repeat (4) @(negedge wr_clk);
        chk("R9 full released within three write edges", 32'(full), 0);
        for (int i = 2; i <= FTHR; i++) begin
            pop_word(d);
            chk($sformatf("R2 word %0d", i), 32'(d), 32'(8'h40 + i));
            chk($sformatf("R5 aempty after read %0d", i), 32'(aempty), 32'((FTHR - i) <= AETHR));
            chk($sformatf("R5 empty after read %0d", i), 32'(empty), 32'(i == FTHR));
        end
        settle();
        chk("R6 overflow word not stored", 32'(empty), 1);
        pop_word(d);
        push_word(8'h77);
        settle();
        chk("R6 read while empty ignored, flag", 32'(empty), 0);
        pop_word(d);
        chk("R6 read while empty ignored, data", 32'(d), 32'h77);
    endtask

    task automatic test_clock_enables();
        logic [DW-1:0] d;
        global_reset();
        @(negedge wr_clk);
        wr_ce = 1'b0; wr_en = 1'b1; wr_data = 8'h11;
        @(negedge wr_clk);
        wr_en = 1'b0; wr_ce = 1'b1;
        settle();
        chk("R7 write without clock enable ignored", 32'(empty), 1);
        push_word(8'h22);
        push_word(8'h33);
        settle();
        @(negedge rd_clk);
        rd_ce = 1'b0; rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0; rd_ce = 1'b1;
        chk("R7 read without clock enable ignored", 32'(rd_data), 32'h22);
        pop_word(d);
        pop_word(d);
        chk("R7 second word after gated read", 32'(d), 32'h33);
        chk("R5 empty after draining", 32'(empty), 1);
    endtask

    task automatic test_retransmit();
        logic [DW-1:0] d;
        global_reset();
        for (int i = 0; i < 5; i++) push_word(DW'(8'hA0 + i));
        settle();
        chk("R5 aempty clear at level 5", 32'(aempty), 0);
        for (int i = 0; i < 5; i++) begin
            pop_word(d);
            chk($sformatf("R2 first pass word %0d", i), 32'(d), 32'(8'hA0 + i));
        end
        chk("R5 empty after first pass", 32'(empty), 1);
        @(negedge rd_clk);
        rd_ptr_rst_n = 1'b0;
        @(negedge rd_clk);
        rd_ptr_rst_n = 1'b1;
        settle();
        chk("R8 data visible after rewind", 32'(empty), 0);
        for (int i = 0; i < 5; i++) begin
            pop_word(d);
            chk($sformatf("R8 replayed word %0d", i), 32'(d), 32'(8'hA0 + i));
        end
        chk("R8 empty after replay", 32'(empty), 1);
    endtask

    task automatic test_reset_midstream();
        for (int i = 0; i < 13; i++) push_word(DW'(i));
        settle();
        chk("R4 afull before reset", 32'(afull), 1);
        @(negedge wr_clk);
        rst_n = 1'b0;
        #1;
        chk("R1 afull cleared by reset", 32'(afull), 0);
        chk("R1 empty set by reset", 32'(empty), 1);
        repeat (2) @(negedge wr_clk);
        rst_n = 1'b1;
        settle();
        chk("R1 empty after midstream reset", 32'(empty), 1);
        chk("R1 aempty after midstream reset", 32'(aempty), 1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        test_reset_state();
        test_fill_drain();
        test_clock_enables();
        test_retransmit();
        test_reset_midstream();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule